// File: doc/BRIEF.md
# DMA Endpoint Staging FIFO Controller

This block moves bytes between a DMA bus port and a USB endpoint buffer through a small first-in first-out stage. A single direction input picks the path. In the IN direction, DMA writes go into the stage and then out to the endpoint. In the OUT direction, endpoint bytes go into the stage and then out to DMA. Every side uses a ready/valid handshake. A 32-bit down-counter holds the number of bytes left in the transfer. Software loads it one byte lane at a time through a small register window. The counter steps down once for each byte accepted on the DMA side.

When the counter limit is enabled, the DMA side is held off once the counter reaches zero. When the limit is disabled, the counter keeps counting and wraps past zero. A stop command ends a transfer early. In the IN direction, the stop lets the staged bytes drain to the endpoint before it reports completion. In the OUT direction, it discards the staged bytes and returns their count, so the endpoint buffer keeps them. Completion sets an interrupt flag, which stays set until software clears it.

Top module: `dma_stage_ctrl`

## Requirements
- R1: After `rst`, the following all hold: `cnt_value` is 0, `stop_irq` is 0, `ep_hold` is 0 and `ep_wvalid` is 0. With `cnt_en`=1, `dma_wready` is 0.
- R2: A write with `reg_wr`=1 updates one byte of the counter. Address 34h writes bits 7:0, 35h writes bits 15:8, 36h writes bits 23:16 and 37h writes bits 31:24. Writes to any other address are ignored. When a lane write and a decrement fall in the same cycle, the written value is kept and no decrement happens.
- R3: The counter drops by one for each byte accepted on the DMA side. In the IN direction that is a `dma_wvalid`/`dma_wready` handshake. In the OUT direction it is a `dma_rvalid`/`dma_rready` handshake.
- R4: With `cnt_en`=1 and the counter at zero, the DMA side offers no handshake: `dma_wready`=0 and `dma_rvalid`=0.
- R5: With `cnt_en`=0, bytes are still accepted when the counter is zero, and the counter wraps from 0 to FFFFFFFFh.
- R6: The stage holds 8 bytes and keeps them in order. When 8 bytes are stored, the filling side's ready (`dma_wready` or `ep_rready`) is 0.
- R7: In the IN direction, a byte accepted at a clock edge appears on `ep_wvalid`/`ep_wdata` right after that same edge.
- R8: In the OUT direction, `ep_hold` is 1 while the stage holds bytes not yet read by DMA. It is 0 once DMA has read them all.
- R9: A `cmd_valid` pulse with `cmd_code`=13h stops the transfer. From the next cycle on, the DMA side accepts nothing and the counter holds its value. Any other code has no effect.
- R10: On an IN stop, the staged bytes are still delivered to the endpoint. `stop_irq` rises only after the stage is empty.
- R11: On an OUT stop, endpoint fetching stops and the staged bytes are discarded. Two edges after the command, `ep_restore` pulses for one cycle with `ep_restore_cnt` equal to the number of discarded bytes. `stop_irq` becomes 1 in the same cycle.
- R12: `stop_irq` stays 1 until `irq_clr` is pulsed. After a stop, both sides stay idle until a counter lane is written, and that write restarts the transfer.
- R13: `bus_rst` clears the counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst | input | 1 | USB bus reset; clears the byte counter |
| dir_in | input | 1 | 1 = IN (DMA to endpoint), 0 = OUT |
| cnt_en | input | 1 | 1 = counter limits the transfer |
| reg_wr | input | 1 | Counter lane write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Lane write data |
| cnt_value | output | 32 | Bytes remaining |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| irq_clr | input | 1 | Clears stop_irq |
| stop_irq | output | 1 | Stop completed flag |
| dma_wvalid | input | 1 | DMA write valid (IN) |
| dma_wdata | input | 8 | DMA write byte |
| dma_wready | output | 1 | Stage accepts DMA byte |
| dma_rvalid | output | 1 | Byte available to DMA (OUT) |
| dma_rdata | output | 8 | Byte to DMA |
| dma_rready | input | 1 | DMA takes byte |
| ep_wvalid | output | 1 | Byte available to endpoint (IN) |
| ep_wdata | output | 8 | Byte to endpoint |
| ep_wready | input | 1 | Endpoint takes byte |
| ep_rvalid | input | 1 | Endpoint byte valid (OUT) |
| ep_rdata | input | 8 | Endpoint byte |
| ep_rready | output | 1 | Stage accepts endpoint byte |
| ep_hold | output | 1 | Endpoint buffer must be kept |
| ep_restore | output | 1 | Pulse: return discarded OUT bytes |
| ep_restore_cnt | output | 4 | Number of bytes returned |

## Verification
The hardest case to reach is an OUT stop that catches the stage partly drained. The stage must hold a known number of bytes, and neither side may move during the two-cycle window before the flush. The bench first fills the stage to 8 bytes while DMA is idle. It then withdraws the endpoint's valid, lets DMA take exactly three bytes and issues the stop, so it expects a restore count of 5. An IN stop is driven with the endpoint stalled, so the flag must stay low while bytes wait. It may rise only after the endpoint is released and the last byte leaves.

// File: rtl/dma_stage_pkg.sv
package dma_stage_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_DRAIN  = 2'd1,
    ST_OFLUSH = 2'd2,
    ST_HALT   = 2'd3
  } stop_st_t;

  localparam logic [7:0] CMD_STOP = 8'h13;
  localparam logic [7:0] CNT_BASE = 8'h34;
endpackage

// File: rtl/stage_fifo.sv
module stage_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // storage without reset so it maps to RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign dout  = mem[rd_ptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/xfer_counter.sv
module xfer_counter #(
  parameter int         CNT_W  = 32,
  parameter int         LANE_W = 8,
  parameter int         ADDR_W = 8,
  parameter logic [7:0] BASE   = 8'h34,
  localparam int        LANES  = CNT_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [LANE_W-1:0] reg_wdata,
  input  logic              dec,
  output logic              any_wr,
  output logic [CNT_W-1:0]  cnt
);
  logic [LANES-1:0] hit;

  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_lane
      assign hit[k] = reg_wr && (reg_addr == ADDR_W'(BASE) + ADDR_W'(k));
    end
  endgenerate

  assign any_wr = |hit;

  always_ff @(posedge clk) begin
    if (rst || bus_rst) begin
      cnt <= '0;
    end else if (any_wr) begin
      for (int i = 0; i < LANES; i++) begin
        if (hit[i]) cnt[i*LANE_W +: LANE_W] <= reg_wdata;
      end
    end else if (dec) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (rst || bus_rst)
    (dec && !any_wr && cnt == '0) |=> (cnt == '1));

  // R2
  lane_low_chk: assert property (@(posedge clk) disable iff (rst || bus_rst)
    hit[0] |=> (cnt[LANE_W-1:0] == $past(reg_wdata)));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (rst || bus_rst)
    (dec && !any_wr) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/stop_ctrl.sv
module stop_ctrl
  import dma_stage_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_code,
  input  logic          dir_in,
  input  logic          cnt_wr,
  input  logic          fifo_empty,
  input  logic [CW-1:0] fifo_count,
  input  logic          irq_clr,
  output stop_st_t      state,
  output logic          flush,
  output logic          restore,
  output logic [CW-1:0] restore_cnt,
  output logic          irq
);
  logic stop_hit;
  logic irq_set;

  assign stop_hit = cmd_valid && (cmd_code == CMD_STOP);
  assign flush    = (state == ST_OFLUSH);
  assign irq_set  = ((state == ST_DRAIN) && fifo_empty) || (state == ST_OFLUSH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_RUN;
      restore     <= 1'b0;
      restore_cnt <= '0;
    end else begin
      restore <= 1'b0;
      case (state)
        ST_RUN:    if (stop_hit) state <= dir_in ? ST_DRAIN : ST_OFLUSH;
        ST_DRAIN:  if (fifo_empty) state <= ST_HALT;
        ST_OFLUSH: begin
          state       <= ST_HALT;
          restore     <= 1'b1;
          restore_cnt <= fifo_count;
        end
        default:   if (cnt_wr) state <= ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          irq <= 1'b0;
    else if (irq_set) irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end

  // R10
  irq_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> fifo_empty);

  // R11
  restore_halt_chk: assert property (@(posedge clk) disable iff (rst)
    restore |-> (irq && state == ST_HALT));

  // R12
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);
endmodule

// File: rtl/dma_stage_ctrl.sv
module dma_stage_ctrl
  import dma_stage_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = 8,
  localparam int FCW       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rst,
  input  logic              dir_in,
  input  logic              cnt_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [CNT_W-1:0]  cnt_value,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic              irq_clr,
  output logic              stop_irq,
  input  logic              dma_wvalid,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic              dma_wready,
  output logic              dma_rvalid,
  output logic [DATA_W-1:0] dma_rdata,
  input  logic              dma_rready,
  output logic              ep_wvalid,
  output logic [DATA_W-1:0] ep_wdata,
  input  logic              ep_wready,
  input  logic              ep_rvalid,
  input  logic [DATA_W-1:0] ep_rdata,
  output logic              ep_rready,
  output logic              ep_hold,
  output logic              ep_restore,
  output logic [FCW-1:0]    ep_restore_cnt
);
  stop_st_t          state;
  logic              run, draining, flush;
  logic              full, empty;
  logic [FCW-1:0]    count;
  logic [DATA_W-1:0] dout;
  logic              cnt_ok, any_wr;
  logic              push_in, pop_in, push_out, pop_out, dec;

  assign run      = (state == ST_RUN);
  assign draining = (state == ST_DRAIN);
  assign cnt_ok   = !cnt_en || (cnt_value != '0);

  // IN path: DMA -> stage -> endpoint
  assign dma_wready = dir_in && run && !full && cnt_ok;
  assign push_in    = dma_wvalid && dma_wready;
  assign ep_wvalid  = dir_in && !empty && (run || draining);
  assign ep_wdata   = dout;
  assign pop_in     = ep_wvalid && ep_wready;

  // OUT path: endpoint -> stage -> DMA
  assign ep_rready  = !dir_in && run && !full;
  assign push_out   = ep_rvalid && ep_rready;
  assign dma_rvalid = !dir_in && run && !empty && cnt_ok;
  assign dma_rdata  = dout;
  assign pop_out    = dma_rvalid && dma_rready;
  assign ep_hold    = !dir_in && !empty;

  assign dec = push_in || pop_out;

  stage_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .push  (push_in || push_out),
    .din   (dir_in ? dma_wdata : ep_rdata),
    .pop   (pop_in || pop_out),
    .dout  (dout),
    .full  (full),
    .empty (empty),
    .count (count)
  );

  xfer_counter #(
    .CNT_W (CNT_W), .LANE_W(8), .ADDR_W(ADDR_W), .BASE(CNT_BASE)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .bus_rst   (bus_rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .dec       (dec),
    .any_wr    (any_wr),
    .cnt       (cnt_value)
  );

  stop_ctrl #(.CW(FCW)) u_stop (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .dir_in      (dir_in),
    .cnt_wr      (any_wr),
    .fifo_empty  (empty),
    .fifo_count  (count),
    .irq_clr     (irq_clr),
    .state       (state),
    .flush       (flush),
    .restore     (ep_restore),
    .restore_cnt (ep_restore_cnt),
    .irq         (stop_irq)
  );

  // R9
  stop_freeze_chk: assert property (@(posedge clk) disable iff (rst || bus_rst)
    (cmd_valid && cmd_code == CMD_STOP && run) |=> (!dma_wready && !dma_rvalid));

  // R7
  in_latency_chk: assert property (@(posedge clk) disable iff (rst)
    push_in |=> (ep_wvalid || !dir_in));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    push_out |=> (ep_hold || dir_in));

  // R4
  limit_chk: assert property (@(posedge clk) disable iff (rst || bus_rst)
    (cnt_en && cnt_value == '0) |-> !dec);
endmodule

// File: tb/dma_stage_ctrl_bench.sv
module dma_stage_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst, bus_rst, dir_in, cnt_en, reg_wr;
  logic [7:0]  reg_addr, reg_wdata, cmd_code;
  logic [31:0] cnt_value;
  logic        cmd_valid, irq_clr, stop_irq;
  logic        dma_wvalid, dma_wready, dma_rvalid, dma_rready;
  logic [7:0]  dma_wdata, dma_rdata, ep_wdata, ep_rdata;
  logic        ep_wvalid, ep_wready, ep_rvalid, ep_rready, ep_hold, ep_restore;
  logic [3:0]  ep_restore_cnt;

  int checks = 0, fails = 0;
  int in_n = 0, out_n = 0, src_n = 0, rest_n = 0;
  logic [3:0] rest_cnt = '0;
  logic [7:0] in_rx [64];
  logic [7:0] out_rx [64];
  bit done = 1'b0;

  always #5 clk = ~clk;

  dma_stage_ctrl u_dma_stage_ctrl (.*);

  assign ep_rdata = 8'hA0 + 8'(src_n);

  always @(posedge clk) begin
    if (ep_wvalid && ep_wready && in_n < 64) begin in_rx[in_n] <= ep_wdata; in_n <= in_n + 1; end
    if (dma_rvalid && dma_rready && out_n < 64) begin out_rx[out_n] <= dma_rdata; out_n <= out_n + 1; end
    if (ep_rvalid && ep_rready) src_n <= src_n + 1;
    if (ep_restore) begin rest_n <= rest_n + 1; rest_cnt <= ep_restore_cnt; end
  end

  // addr, data, expected counter after the write
  localparam logic [47:0] LANE_TBL [8] = '{
    {8'h34, 8'h11, 32'h0000_0011},
    {8'h35, 8'h22, 32'h0000_2211},
    {8'h36, 8'h33, 32'h0033_2211},
    {8'h37, 8'h44, 32'h4433_2211},
    {8'h38, 8'hFF, 32'h4433_2211},
    {8'h33, 8'hFF, 32'h4433_2211},
    {8'h37, 8'h00, 32'h0033_2211},
    {8'h34, 8'hAB, 32'h0033_22AB}
  };

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_lane(logic [7:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic load_cnt(logic [31:0] v);
    for (int i = 0; i < 4; i++) wr_lane(8'h34 + 8'(i), v[i*8 +: 8]);
  endtask

  task automatic cmd(logic [7:0] c);
    cmd_valid = 1'b1; cmd_code = c;
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    int base;
    rst = 1; bus_rst = 0; dir_in = 1; cnt_en = 1; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    cmd_valid = 0; cmd_code = 0; irq_clr = 0; dma_wvalid = 0; dma_wdata = 0;
    dma_rready = 0; ep_wready = 0; ep_rvalid = 0;
    tick(3);
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 cnt", cnt_value, 0);
    chk("R1 irq", 32'(stop_irq), 0);
    chk("R1 ep_wvalid", 32'(ep_wvalid), 0);
    chk("R1 ep_hold", 32'(ep_hold), 0);
    chk("R4 wready at zero", 32'(dma_wready), 0);

    // R2 lane table
    for (int i = 0; i < 8; i++) begin
      wr_lane(LANE_TBL[i][47:40], LANE_TBL[i][39:32]);
      chk("R2 lane write", cnt_value, LANE_TBL[i][31:0]);
    end

    // R2 write beats decrement
    dma_wvalid = 1; dma_wdata = 8'h77;
    wr_lane(8'h34, 8'h05);
    dma_wvalid = 0;
    chk("R2 write wins", cnt_value, 32'h0033_2205);
    ep_wready = 1; tick(2);

    // R3/R4 counter limits the transfer
    base = in_n;
    load_cnt(3);
    for (int i = 0; i < 6; i++) begin
      dma_wvalid = 1; dma_wdata = 8'h10 + 8'(i); tick();
    end
    dma_wvalid = 0; tick(2);
    chk("R3 cnt after 3", cnt_value, 0);
    chk("R4 wready off", 32'(dma_wready), 0);
    chk("R4 accepted", 32'(in_n - base), 3);
    chk("R4 byte2", 32'(in_rx[base + 2]), 32'h12);

    // R7 one-cycle visibility
    ep_wready = 0;
    load_cnt(10);
    dma_wvalid = 1; dma_wdata = 8'h55; tick(); dma_wvalid = 0;
    chk("R7 ep_wvalid", 32'(ep_wvalid), 1);
    chk("R7 ep_wdata", 32'(ep_wdata), 32'h55);
    ep_wready = 1; tick(2);

    // R6 depth and order
    ep_wready = 0; base = in_n;
    load_cnt(20);
    for (int i = 0; i < 10; i++) begin
      dma_wvalid = 1; dma_wdata = 8'h20 + 8'(i); tick();
    end
    dma_wvalid = 0;
    chk("R6 full wready", 32'(dma_wready), 0);
    chk("R3 cnt after 8", cnt_value, 12);
    ep_wready = 1; tick(10);
    chk("R6 drained", 32'(in_n - base), 8);
    for (int i = 0; i < 8; i++) chk("R6 order", 32'(in_rx[base + i]), 32'h20 + 32'(i));

    // R5 wrap with limit disabled
    cnt_en = 0;
    load_cnt(1);
    dma_wvalid = 1; tick(2); dma_wvalid = 0;
    chk("R5 wrap", cnt_value, 32'hFFFF_FFFF);
    cnt_en = 1; tick(2);

    // R9 other codes ignored
    cmd(8'h21);
    tick();
    chk("R9 ignore irq", 32'(stop_irq), 0);
    chk("R9 ignore run", 32'(dma_wready), 1);

    // R10 IN stop drains before irq
    ep_wready = 0; base = in_n;
    load_cnt(20);
    for (int i = 0; i < 3; i++) begin
      dma_wvalid = 1; dma_wdata = 8'h30 + 8'(i); tick();
    end
    dma_wvalid = 0;
    cmd(8'h13);
    chk("R9 stop blocks", 32'(dma_wready), 0);
    chk("R9 cnt frozen", cnt_value, 17);
    tick(3);
    chk("R10 irq waits", 32'(stop_irq), 0);
    ep_wready = 1; tick(10);
    chk("R10 irq", 32'(stop_irq), 1);
    chk("R10 delivered", 32'(in_n - base), 3);
    chk("R10 last byte", 32'(in_rx[base + 2]), 32'h32);

    // R12 sticky flag, restart by counter write
    tick(5);
    chk("R12 sticky", 32'(stop_irq), 1);
    chk("R12 halted", 32'(dma_wready), 0);
    irq_clr = 1; tick(); irq_clr = 0;
    chk("R12 cleared", 32'(stop_irq), 0);
    load_cnt(5);
    chk("R12 restart", 32'(dma_wready), 1);

    // R13 bus reset
    bus_rst = 1; tick(); bus_rst = 0;
    chk("R13 cnt", cnt_value, 0);

    // OUT direction: fill, partial read, stop
    dir_in = 0; ep_wready = 0;
    load_cnt(100);
    ep_rvalid = 1; tick(12); ep_rvalid = 0;
    chk("R6 out full", 32'(ep_rready), 0);
    chk("R6 out fetched", 32'(src_n), 8);
    chk("R8 hold", 32'(ep_hold), 1);
    dma_rready = 1; tick(3); dma_rready = 0;
    chk("R3 out cnt", cnt_value, 97);
    chk("R6 out b0", 32'(out_rx[0]), 32'hA0);
    chk("R6 out b2", 32'(out_rx[2]), 32'hA2);
    cmd(8'h13);
    tick(3);
    chk("R11 restore pulses", 32'(rest_n), 1);
    chk("R11 restore cnt", 32'(rest_cnt), 5);
    chk("R11 irq", 32'(stop_irq), 1);
    chk("R11 hold off", 32'(ep_hold), 0);
    chk("R11 no dma", 32'(dma_rvalid), 0);

    // R8 hold released after DMA reads all
    irq_clr = 1; tick(); irq_clr = 0;
    load_cnt(2);
    ep_rvalid = 1; tick(2); ep_rvalid = 0;
    chk("R8 hold set", 32'(ep_hold), 1);
    dma_rready = 1; tick(2); dma_rready = 0;
    chk("R8 hold clear", 32'(ep_hold), 0);
    chk("R8 data", 32'(out_rx[4]), 32'hA9);
    chk("R4 out limit", 32'(dma_rvalid), 0);

    done = 1'b1;
    report();
  end
endmodule